// File: doc/BRIEF.md
# NRZI Line Coder with Zero Stuffing

This block is the bit-level coder pair for a serial packet link that carries its clock in the data transitions. On the transmit side a producer offers one payload bit per bit time through a valid/ready handshake, with a marker on the final bit of a packet. The coder inserts a zero after every run of six ones so that the line always changes often enough for clock recovery. It then encodes the stream so that a zero changes the line level and a one leaves it alone. The result appears on a single line-level output, together with a strobe for each line bit and a strobe for the final line bit.

On the receive side, line levels arrive with a valid strobe and an end marker. The block turns level changes back into bits and drops the inserted zero that follows each run of six ones. It delivers the payload bits with a valid strobe and reports the end of the packet. When the bit after six ones is not a zero, it raises a packet-scoped error flag. All state advances only in clock cycles where the bit-time enable is high, so the line may run slower than the system clock. Multi-bit fields are expected least-significant bit first; the block itself works bit by bit.

Top module: `nrzi_stuff_codec`

## Requirements
- R1: Each transmitted line bit appears one clock after the enabled edge that takes it. A 0 inverts `tx_line` and a 1 keeps it, and every line bit is marked by a one-clock pulse on `tx_line_valid`.
- R2: After six consecutive ones on the line (payload ones counted since the last zero), the transmitter puts a 0 on the line before the next payload bit.
- R3: During the bit time in which the inserted zero is sent, `tx_ready` is low and the offered payload bit is not taken; it is sent in the following bit time.
- R4: Both an inserted zero and a payload zero restart the count of ones. Twelve payload ones therefore go out as six ones, a zero, six ones and a zero.
- R5: When a packet ends with a run of six ones, the inserted zero is still sent and `tx_line_last` marks it instead of the last payload bit. The run count starts from zero for the next packet.
- R6: After reset and in every enabled bit time with no bit to send, `tx_line` is 1. The first bit of a packet that follows an idle bit time is referenced to that level, and the receiver also takes level 1 as its reference after a bit time with `rx_valid` low. After reset `tx_ready` is 1 and `tx_line_valid`, `rx_data_valid` and `rx_err` are 0.
- R7: The receiver decodes a received level equal to the previous one as 1 and a changed level as 0. It delivers each payload bit on `rx_data` with a one-clock `rx_data_valid` pulse one clock after the enabled edge, and it never delivers the bit that follows six decoded ones.
- R8: `rx_end` pulses one clock after the enabled edge that takes the line bit marked by `rx_last`, also when that bit is a dropped inserted zero.
- R9: If the bit after six decoded ones decodes as 1, `rx_err` goes high and stays high until the first bit of the next packet is taken, when it clears. Payload delivery is otherwise unaffected.
- R10: In a cycle with `bit_en` low no input is taken, no strobe is produced and `tx_line` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-time enable; all state advances only when high |
| tx_valid | input | 1 | Payload bit offered |
| tx_bit | input | 1 | Payload bit value |
| tx_last | input | 1 | Offered bit is the last of its packet |
| tx_ready | output | 1 | Offered bit is taken at the next enabled edge |
| tx_line | output | 1 | Encoded line level |
| tx_line_valid | output | 1 | One-clock pulse for each line bit |
| tx_line_last | output | 1 | One-clock pulse with the final line bit of a packet |
| rx_line | input | 1 | Received line level |
| rx_valid | input | 1 | Received line bit present |
| rx_last | input | 1 | Received line bit is the last of its packet |
| rx_data | output | 1 | Decoded payload bit |
| rx_data_valid | output | 1 | One-clock pulse for each payload bit |
| rx_end | output | 1 | One-clock pulse at packet end |
| rx_err | output | 1 | Stuffing violation seen in the current or last packet |

## Verification
The assertions assume that the producer holds `tx_valid` and its bit steady until they are taken, and that a received packet follows at least one bit time with `rx_valid` low, so the level reference is the idle level. The bench drives every packet after two idle bit times, and it keeps the offered bit in place through each inserted-zero bit time. Received streams are built from a bench-side model of stuffing and level coding. The only departures from that model are deliberate: an inserted zero is turned into a one to provoke the error. The bit-time enable is dropped for whole clock cycles only, never in the middle of a handshake.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;

    // Length of the run of ones that forces an inserted zero.
    localparam int STUFF_RUN = 6;

    // Line level while nothing is being sent.
    localparam logic LINE_IDLE = 1'b1;

    // One bit handed from the stuffer to the level coder.
    typedef struct packed {
        logic vld;
        logic dat;
        logic lst;
    } line_bit_t;

    function automatic int run_cnt_w(input int run);
        return $clog2(run + 1);
    endfunction

endpackage

// File: rtl/stuff_insert.sv
module stuff_insert
    import nrzi_pkg::*;
#(
    parameter int RUN_LEN = STUFF_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      tx_valid,
    input  logic      tx_bit,
    input  logic      tx_last,
    output logic      tx_ready,
    output line_bit_t sbit
);
    localparam int CNT_W = run_cnt_w(RUN_LEN);
    localparam logic [CNT_W-1:0] RUN_C  = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] NEAR_C = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] ones_cnt;
    logic             stuff_is_last;
    logic             at_run;
    logic             take;
    logic             closes_run;

    assign at_run     = (ones_cnt == RUN_C);
    assign tx_ready   = !at_run;
    assign take       = bit_en && tx_valid && !at_run;
    assign closes_run = tx_bit && (ones_cnt == NEAR_C);

    always_comb begin
        sbit = '0;
        if (at_run) begin
            sbit.vld = 1'b1;
            sbit.dat = 1'b0;
            sbit.lst = stuff_is_last;
        end else if (tx_valid) begin
            sbit.vld = 1'b1;
            sbit.dat = tx_bit;
            sbit.lst = tx_last && !closes_run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt      <= '0;
            stuff_is_last <= 1'b0;
        end else if (bit_en) begin
            if (at_run) begin
                ones_cnt      <= '0;
                stuff_is_last <= 1'b0;
            end else if (take) begin
                if (tx_bit)
                    ones_cnt <= ones_cnt + 1'b1;
                else
                    ones_cnt <= '0;
                stuff_is_last <= tx_last && closes_run;
                if (tx_last && !closes_run)
                    ones_cnt <= '0;
            end
        end
    end

    AST_STUFF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bit_en && at_run |-> sbit.vld && !sbit.dat); // R2

    AST_SIXTH_ONE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        take && closes_run |=> !tx_ready); // R3

    AST_RUN_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        bit_en && at_run |=> ones_cnt == '0); // R4

endmodule

// File: rtl/nrzi_encode.sv
module nrzi_encode
    import nrzi_pkg::*;
#(
    parameter logic IDLE_LVL = LINE_IDLE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  line_bit_t sbit,
    output logic      tx_line,
    output logic      tx_line_valid,
    output logic      tx_line_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_line       <= IDLE_LVL;
            tx_line_valid <= 1'b0;
            tx_line_last  <= 1'b0;
        end else begin
            tx_line_valid <= bit_en && sbit.vld;
            tx_line_last  <= bit_en && sbit.vld && sbit.lst;
            if (bit_en) begin
                if (!sbit.vld)
                    tx_line <= IDLE_LVL;
                else if (!sbit.dat)
                    tx_line <= !tx_line;
            end
        end
    end

    AST_ONE_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        bit_en && sbit.vld && sbit.dat |=> tx_line == $past(tx_line)); // R1

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        bit_en && !sbit.vld |=> tx_line == IDLE_LVL); // R6

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> !tx_line_valid && $stable(tx_line)); // R10

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_line_last |-> tx_line_valid); // R5

endmodule

// File: rtl/nrzi_decode.sv
module nrzi_decode
    import nrzi_pkg::*;
#(
    parameter logic IDLE_LVL = LINE_IDLE
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic rx_line,
    input  logic rx_valid,
    output logic dec_bit
);
    logic ref_lvl;

    assign dec_bit = (rx_line == ref_lvl);

    always_ff @(posedge clk) begin
        if (rst)
            ref_lvl <= IDLE_LVL;
        else if (bit_en)
            ref_lvl <= rx_valid ? rx_line : IDLE_LVL;
    end

    AST_REF_IDLE: assert property (@(posedge clk) disable iff (rst)
        bit_en && !rx_valid |=> ref_lvl == IDLE_LVL); // R6

endmodule

// File: rtl/stuff_remove.sv
module stuff_remove
    import nrzi_pkg::*;
#(
    parameter int RUN_LEN = STUFF_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic in_vld,
    input  logic in_bit,
    input  logic in_last,
    output logic rx_data,
    output logic rx_data_valid,
    output logic rx_end,
    output logic rx_err
);
    localparam int CNT_W = run_cnt_w(RUN_LEN);
    localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] ones_cnt;
    logic             fresh;
    logic             at_run;
    logic             err_base;

    assign at_run   = (ones_cnt == RUN_C);
    assign err_base = fresh ? 1'b0 : rx_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt      <= '0;
            fresh         <= 1'b1;
            rx_err        <= 1'b0;
            rx_data       <= 1'b0;
            rx_data_valid <= 1'b0;
            rx_end        <= 1'b0;
        end else begin
            rx_data_valid <= 1'b0;
            rx_end        <= 1'b0;
            if (bit_en && in_vld) begin
                fresh <= in_last;
                if (at_run) begin
                    ones_cnt <= '0;
                    rx_err   <= err_base | in_bit;
                end else begin
                    rx_err        <= err_base;
                    rx_data_valid <= 1'b1;
                    rx_data       <= in_bit;
                    ones_cnt      <= in_bit ? ones_cnt + 1'b1 : '0;
                end
                if (in_last) begin
                    ones_cnt <= '0;
                    rx_end   <= 1'b1;
                end
            end
        end
    end

    AST_DROP_STUFFED: assert property (@(posedge clk) disable iff (rst)
        bit_en && in_vld && at_run |=> !rx_data_valid); // R7

    AST_FLAG_VIOLATION: assert property (@(posedge clk) disable iff (rst)
        bit_en && in_vld && at_run && in_bit |=> rx_err); // R9

    AST_END_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        bit_en && in_vld && in_last |=> rx_end); // R8

endmodule

// File: rtl/nrzi_stuff_codec.sv
module nrzi_stuff_codec
    import nrzi_pkg::*;
#(
    parameter int   RUN_LEN  = STUFF_RUN,
    parameter logic IDLE_LVL = LINE_IDLE
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic tx_valid,
    input  logic tx_bit,
    input  logic tx_last,
    output logic tx_ready,
    output logic tx_line,
    output logic tx_line_valid,
    output logic tx_line_last,
    input  logic rx_line,
    input  logic rx_valid,
    input  logic rx_last,
    output logic rx_data,
    output logic rx_data_valid,
    output logic rx_end,
    output logic rx_err
);
    line_bit_t sbit;
    logic      dec_bit;

    stuff_insert #(.RUN_LEN(RUN_LEN)) u_stuff_insert (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .tx_valid (tx_valid),
        .tx_bit   (tx_bit),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .sbit     (sbit)
    );

    nrzi_encode #(.IDLE_LVL(IDLE_LVL)) u_nrzi_encode (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .sbit          (sbit),
        .tx_line       (tx_line),
        .tx_line_valid (tx_line_valid),
        .tx_line_last  (tx_line_last)
    );

    nrzi_decode #(.IDLE_LVL(IDLE_LVL)) u_nrzi_decode (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .rx_line  (rx_line),
        .rx_valid (rx_valid),
        .dec_bit  (dec_bit)
    );

    stuff_remove #(.RUN_LEN(RUN_LEN)) u_stuff_remove (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .in_vld        (rx_valid),
        .in_bit        (dec_bit),
        .in_last       (rx_last),
        .rx_data       (rx_data),
        .rx_data_valid (rx_data_valid),
        .rx_end        (rx_end),
        .rx_err        (rx_err)
    );

endmodule

// File: tb/test_nrzi_stuff_codec.sv
module test_nrzi_stuff_codec;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic tx_valid = 1'b0, tx_bit = 1'b0, tx_last = 1'b0;
    logic rx_line = 1'b1, rx_valid = 1'b0, rx_last = 1'b0;
    logic tx_ready, tx_line, tx_line_valid, tx_line_last;
    logic rx_data, rx_data_valid, rx_end, rx_err;

    int n_err = 0;
    int n_chk = 0;
    bit done = 1'b0;

    logic sbits  [128];
    logic sstuff [128];
    int   slen;

    always #2 clk = ~clk;

    nrzi_stuff_codec i_nrzi_stuff_codec (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_line(tx_line),
        .tx_line_valid(tx_line_valid), .tx_line_last(tx_line_last),
        .rx_line(rx_line), .rx_valid(rx_valid), .rx_last(rx_last),
        .rx_data(rx_data), .rx_data_valid(rx_data_valid),
        .rx_end(rx_end), .rx_err(rx_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference stuffing model: payload d[0..n-1], sent bit 0 first.
    task automatic build(input logic [63:0] d, input int n);
        int run = 0;
        slen = 0;
        for (int i = 0; i < n; i++) begin
            sbits[slen] = d[i]; sstuff[slen] = 1'b0; slen++;
            run = d[i] ? run + 1 : 0;
            if (run == 6) begin
                sbits[slen] = 1'b0; sstuff[slen] = 1'b1; slen++;
                run = 0;
            end
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            bit_en = 1'b1; tx_valid = 1'b0; tx_last = 1'b0;
            rx_valid = 1'b0; rx_last = 1'b0;
        end
        @(posedge clk); #1;
    endtask

    task automatic tx_packet(input logic [63:0] d, input int n, input bit gap,
                             input string req, input string nm);
        logic lvl = 1'b1;
        int di = 0, bad_line = 0, bad_rdy = 0, bad_last = 0, bad_gap = 0;
        build(d, n);
        idle(2);
        for (int j = 0; j < slen; j++) begin
            if (gap) begin
                for (int g = 0; g < 2; g++) begin
                    @(negedge clk);
                    bit_en = 1'b0; tx_valid = (di < n); tx_bit = d[di % 64];
                    tx_last = (di == n - 1);
                    @(posedge clk); #1;
                    if (tx_line_valid || tx_line_last || tx_line !== lvl) bad_gap++;
                end
            end
            @(negedge clk);
            bit_en = 1'b1;
            if (di < n) begin
                tx_valid = 1'b1; tx_bit = d[di]; tx_last = (di == n - 1);
            end else begin
                tx_valid = 1'b0; tx_last = 1'b0;
            end
            #1;
            if (tx_ready !== !sstuff[j]) bad_rdy++;
            @(posedge clk); #1;
            lvl = sbits[j] ? lvl : ~lvl;
            if (tx_line_valid !== 1'b1 || tx_line !== lvl) bad_line++;
            if (tx_line_last !== (j == slen - 1)) bad_last++;
            if (!sstuff[j]) di++;
        end
        idle(1);
        check(bad_line == 0, req, {nm, " line levels (R1/R2/R4)"}, bad_line, 0);
        check(bad_rdy == 0, "R3", {nm, " ready during inserted zero"}, bad_rdy, 0);
        check(bad_last == 0, "R5", {nm, " last marker position"}, bad_last, 0);
        check(tx_line === 1'b1 && tx_line_valid === 1'b0, "R6",
              {nm, " idle level after packet"}, tx_line, 1);
        if (gap) check(bad_gap == 0, "R10", {nm, " quiet while bit_en low"}, bad_gap, 0);
    endtask

    task automatic rx_packet(input logic [63:0] d, input int n, input int corrupt,
                             input bit exp_err, input string nm);
        logic lvl = 1'b1;
        logic [63:0] got = '0;
        int gi = 0, bad_v = 0, bad_end = 0, sc = 0;
        build(d, n);
        for (int j = 0; j < slen; j++)
            if (sstuff[j]) begin
                if (sc == corrupt) sbits[j] = 1'b1;
                sc++;
            end
        idle(2);
        for (int j = 0; j < slen; j++) begin
            @(negedge clk);
            bit_en = 1'b1; rx_valid = 1'b1;
            lvl = sbits[j] ? lvl : ~lvl;
            rx_line = lvl; rx_last = (j == slen - 1);
            @(posedge clk); #1;
            if (rx_data_valid) begin
                if (sstuff[j] || gi > 63) bad_v++;
                else begin got[gi] = rx_data; gi++; end
            end else if (!sstuff[j]) bad_v++;
            if (rx_end !== (j == slen - 1)) bad_end++;
        end
        idle(1);
        check(bad_v == 0 && gi == n, "R7", {nm, " delivered bit slots"}, gi, n);
        check(got == (d & ((64'd1 << n) - 64'd1)), "R7", {nm, " delivered data"},
              int'(got[31:0]), int'(d[31:0]));
        check(bad_end == 0, "R8", {nm, " end pulse"}, bad_end, 0);
        check(rx_err === exp_err, "R9", {nm, " error flag"}, rx_err, exp_err);
    endtask

    task automatic test_reset;
        @(posedge clk); #1;
        check(tx_line === 1'b1, "R6", "reset line level", tx_line, 1);
        check(tx_ready === 1'b1, "R6", "reset ready", tx_ready, 1);
        check(tx_line_valid === 1'b0 && rx_data_valid === 1'b0, "R6",
              "reset strobes", tx_line_valid, 0);
        check(rx_err === 1'b0, "R6", "reset error flag", rx_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk); rst = 1'b0;
        tx_packet(64'hA5, 8, 1'b0, "R1", "tx mixed byte");
        tx_packet(64'h00, 8, 1'b0, "R1", "tx all zeros");
        tx_packet(64'hFF, 8, 1'b0, "R2", "tx eight ones");
        tx_packet(64'hFFF, 12, 1'b0, "R4", "tx twelve ones");
        tx_packet(64'h3F, 6, 1'b0, "R5", "tx six ones at end");
        tx_packet(64'h3F, 6, 1'b0, "R5", "tx next packet run restart");
        tx_packet(64'h7F3F, 16, 1'b1, "R10", "tx with enable gaps");
        rx_packet(64'hA5, 8, -1, 1'b0, "rx mixed byte");
        rx_packet(64'hFFF, 12, -1, 1'b0, "rx twelve ones");
        rx_packet(64'h3F, 6, -1, 1'b0, "rx ends on inserted zero");
        rx_packet(64'hC0FF, 16, 0, 1'b1, "rx corrupted inserted zero");
        rx_packet(64'h5A, 8, -1, 1'b0, "rx clean packet clears error");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule